// File: doc/BRIEF.md
# Multi-Thread Gate Control List Sequencer

This block is the timing core of a time-aware egress scheduler in a switch. Up to eight execution threads walk cyclically through one shared, linear table of gate-control entries. Each thread owns a slice of that table: it begins at its own entry address, runs forward to its own end index, and then jumps back to the entry address and repeats. Every table entry names a set of egress ports and a per-traffic-class close mask, and it stays in force for a programmed number of time units before the thread moves on.

Software arms the block by writing the table and the per-thread entry points, setting a common schedule start time, and issuing a start command. Each thread then waits until the PTP time reaches the common start time plus its own offset, so that schedules on different ports can be phase-shifted against each other. The block combines the entries of all running threads into one gate-closed mask per port. A stop command idles every thread at once, and a later start replays each thread from its entry address.

Top module: `gcl_sequencer`

## Requirements
- R1: After reset no thread runs, every gate-closed bit is 0, the running status is 0 and the stopped status is 1.
- R2: A start command sets the running status to 1 and the stopped status to 0 from the next cycle on; a stop command returns them to 0 and 1 in the same way.
- R3: An enabled thread begins on the first clock edge, after the running status has been set, at which the sampled PTP time is at least the schedule start time plus its entry-point offset times TPU (ticks per unit); it begins at its entry address.
- R4: Thread i is enabled only when i is less than or equal to the active-count field (number of active threads minus one); a disabled thread never runs and closes nothing.
- R5: A running thread holds each table entry for exactly its delta field times TPU clock cycles, then moves to the next index.
- R6: After holding its end index, a thread returns to its entry address and repeats the same sequence.
- R7: The gate-closed mask of port p (bits p*NC to p*NC+NC-1) is the bitwise OR of the close masks of the current entries of all running threads whose port mask has bit p set; a set bit blocks that traffic class.
- R8: A thread that has not yet begun, or that has been stopped, contributes an all-open mask.
- R9: A stop command idles all threads at the same clock edge, even if it coincides with an entry boundary or a thread's start instant, and wins over a start command given in the same cycle; the next start replays every thread from its entry address.
- R10: An entry-point write whose offset field is zero is dropped entirely; the thread keeps its previous entry address, end index and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock, one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptp_time | input | TIME_W | Current PTP time in ticks |
| sched_start | input | TIME_W | Common schedule start time in ticks |
| start_cmd | input | 1 | Start pulse |
| stop_cmd | input | 1 | Stop pulse, priority over start |
| act_m1 | input | THR_W | Number of active threads minus one |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_delta | input | DELTA_W | Entry hold time in units |
| tbl_ports | input | NP | Entry destination-port mask |
| tbl_close | input | NC | Entry traffic-class close mask |
| ep_we | input | 1 | Entry-point write strobe |
| ep_sel | input | THR_W | Thread selected by the entry-point write |
| ep_addr | input | IDX_W | Thread entry address |
| ep_delta | input | DELTA_W | Thread start offset in units, must be nonzero |
| ep_end | input | IDX_W | Thread end index |
| gate_closed | output | NP*NC | Per-port traffic-class closed bits |
| thr_running | output | NT | Per-thread running flags |
| sts_running | output | 1 | Schedule started status |
| sts_stopped | output | 1 | Schedule stopped status |

## Verification
The stop command can fall in the same cycle as a thread's entry boundary, its wrap to the entry address or its start instant, and a start command can coincide with a stop. The bench sweeps the stop point across every cycle offset of a full schedule period after each restart, and also issues start and stop together. A cycle-accurate arithmetic model tracks each thread's start edge and derives its position from the elapsed cycles modulo the period, so after every edge it judges whether all gates opened at once and whether the following start replayed each thread from its entry address.

// File: rtl/gcl_seq_pkg.sv
package gcl_seq_pkg;
    // Life cycle of one execution thread.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // schedule not armed or thread disabled
        PH_WAIT = 2'd1,   // armed, waiting for its start instant
        PH_RUN  = 2'd2    // stepping through its table slice
    } phase_e;
endpackage

// File: rtl/gcl_table.sv
module gcl_table #(
    parameter int DEPTH   = 16,
    parameter int NT      = 8,
    parameter int NP      = 4,
    parameter int NC      = 8,
    parameter int DELTA_W = 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [DELTA_W-1:0]    wr_delta,
    input  logic [NP-1:0]         wr_ports,
    input  logic [NC-1:0]         wr_close,
    input  logic [NT*IDX_W-1:0]   rd_addr,
    output logic [NT*DELTA_W-1:0] rd_delta,
    output logic [NT*NP-1:0]      rd_ports,
    output logic [NT*NC-1:0]      rd_close
);
    typedef struct packed {
        logic [DELTA_W-1:0] delta;
        logic [NP-1:0]      ports;
        logic [NC-1:0]      close;
    } ent_t;

    ent_t [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr].delta = wr_delta;
            mem_d[wr_addr].ports = wr_ports;
            mem_d[wr_addr].close = wr_close;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    for (genvar t = 0; t < NT; t++) begin : g_rd
        logic [IDX_W-1:0] a;
        assign a = rd_addr[t*IDX_W +: IDX_W];
        assign rd_delta[t*DELTA_W +: DELTA_W] = mem_q[a].delta;
        assign rd_ports[t*NP +: NP]           = mem_q[a].ports;
        assign rd_close[t*NC +: NC]           = mem_q[a].close;
    end
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
    import gcl_seq_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int DELTA_W = 8,
    parameter int TIME_W  = 32,
    parameter int TPU     = 25,
    localparam int CNT_W  = DELTA_W + $clog2(TPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               stop,
    input  logic               active,
    input  logic [TIME_W-1:0]  ptp_time,
    input  logic [TIME_W-1:0]  start_time,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_addr,
    input  logic [DELTA_W-1:0] cfg_delta,
    input  logic [IDX_W-1:0]   cfg_end,
    input  logic [DELTA_W-1:0] cur_delta,
    output logic               running,
    output logic [IDX_W-1:0]   ptr
);
    typedef struct packed {
        phase_e             ph;
        logic [IDX_W-1:0]   ptr;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   base;
        logic [IDX_W-1:0]   last;
        logic [DELTA_W-1:0] ofs;
    } thr_t;

    thr_t             q, d;
    logic [TIME_W-1:0] due;
    logic              reached;
    logic [CNT_W-1:0]  dur_m1;

    assign due     = start_time + (TIME_W'(q.ofs) * TIME_W'(TPU));
    assign reached = (ptp_time >= due);
    assign dur_m1  = (cur_delta == '0) ? '0
                   : CNT_W'(cur_delta) * CNT_W'(TPU) - CNT_W'(1);

    always_comb begin
        d = q;
        if (cfg_we && cfg_delta != '0) begin
            d.base = cfg_addr;
            d.last = cfg_end;
            d.ofs  = cfg_delta;
        end
        if (stop || !run || !active) begin
            d.ph  = PH_IDLE;
            d.ptr = '0;
            d.cnt = '0;
        end else begin
            case (q.ph)
                PH_IDLE, PH_WAIT: begin
                    if (reached) begin
                        d.ph  = PH_RUN;
                        d.ptr = q.base;
                        d.cnt = '0;
                    end else begin
                        d.ph  = PH_WAIT;
                    end
                end
                PH_RUN: begin
                    if (q.cnt == dur_m1) begin
                        d.cnt = '0;
                        d.ptr = (q.ptr == q.last) ? q.base : q.ptr + IDX_W'(1);
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.ofs  <= DELTA_W'(1);
        end else begin
            q <= d;
        end
    end

    assign running = (q.ph == PH_RUN);
    assign ptr     = q.ptr;

    AST_THREAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q.ph != PH_RUN)); // R4
    AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && q.cnt != '0) |-> (q.ptr == $past(q.ptr))); // R5
    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && $past(q.ph) == PH_RUN && q.ptr != $past(q.ptr))
        |-> (q.ptr == $past(q.ptr) + IDX_W'(1) || q.ptr == $past(q.base))); // R6
endmodule

// File: rtl/gcl_gate_merge.sv
module gcl_gate_merge #(
    parameter int NT = 8,
    parameter int NP = 4,
    parameter int NC = 8
) (
    input  logic [NT-1:0]    running,
    input  logic [NT*NP-1:0] ports,
    input  logic [NT*NC-1:0] close,
    output logic [NP*NC-1:0] gate_closed
);
    always_comb begin
        gate_closed = '0;
        for (int t = 0; t < NT; t++) begin
            for (int p = 0; p < NP; p++) begin
                if (running[t] && ports[t*NP + p])
                    gate_closed[p*NC +: NC] = gate_closed[p*NC +: NC] | close[t*NC +: NC];
            end
        end
    end
endmodule

// File: rtl/gcl_sequencer.sv
module gcl_sequencer #(
    parameter int NT      = 8,
    parameter int NP      = 4,
    parameter int NC      = 8,
    parameter int DEPTH   = 16,
    parameter int DELTA_W = 8,
    parameter int TIME_W  = 32,
    parameter int TPU     = 25,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int THR_W  = $clog2(NT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  ptp_time,
    input  logic [TIME_W-1:0]  sched_start,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic [THR_W-1:0]   act_m1,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [DELTA_W-1:0] tbl_delta,
    input  logic [NP-1:0]      tbl_ports,
    input  logic [NC-1:0]      tbl_close,
    input  logic               ep_we,
    input  logic [THR_W-1:0]   ep_sel,
    input  logic [IDX_W-1:0]   ep_addr,
    input  logic [DELTA_W-1:0] ep_delta,
    input  logic [IDX_W-1:0]   ep_end,
    output logic [NP*NC-1:0]   gate_closed,
    output logic [NT-1:0]      thr_running,
    output logic               sts_running,
    output logic               sts_stopped
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (stop_cmd)       run_d = 1'b0;
        else if (start_cmd) run_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign sts_running = run_q;
    assign sts_stopped = !run_q;

    logic [NT*IDX_W-1:0]   rd_addr;
    logic [NT*DELTA_W-1:0] rd_delta;
    logic [NT*NP-1:0]      rd_ports;
    logic [NT*NC-1:0]      rd_close;

    gcl_table #(
        .DEPTH(DEPTH), .NT(NT), .NP(NP), .NC(NC), .DELTA_W(DELTA_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_delta(tbl_delta),
        .wr_ports(tbl_ports), .wr_close(tbl_close),
        .rd_addr(rd_addr), .rd_delta(rd_delta),
        .rd_ports(rd_ports), .rd_close(rd_close)
    );

    for (genvar g = 0; g < NT; g++) begin : g_thr
        logic sel, en;
        assign sel = ep_we && (ep_sel == THR_W'(g));
        assign en  = (THR_W'(g) <= act_m1);

        gcl_thread #(
            .IDX_W(IDX_W), .DELTA_W(DELTA_W), .TIME_W(TIME_W), .TPU(TPU)
        ) u_thr (
            .clk(clk), .rst_n(rst_n),
            .run(run_q), .stop(stop_cmd), .active(en),
            .ptp_time(ptp_time), .start_time(sched_start),
            .cfg_we(sel), .cfg_addr(ep_addr), .cfg_delta(ep_delta), .cfg_end(ep_end),
            .cur_delta(rd_delta[g*DELTA_W +: DELTA_W]),
            .running(thr_running[g]),
            .ptr(rd_addr[g*IDX_W +: IDX_W])
        );
    end

    gcl_gate_merge #(.NT(NT), .NP(NP), .NC(NC)) u_merge (
        .running(thr_running), .ports(rd_ports), .close(rd_close),
        .gate_closed(gate_closed)
    );

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (thr_running == '0 && !sts_running)); // R9
    AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(thr_running & ~$past(thr_running))) |-> $past(run_q)); // R3
    AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (gate_closed == '0)); // R8
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_running) |-> $past(start_cmd) && !$past(stop_cmd)); // R2
endmodule

// File: tb/gcl_sequencer_test.sv
module gcl_sequencer_test;
    localparam int NT = 8, NP = 4, NC = 8, DEPTH = 16, DW = 6, TW = 24, TPU = 2;
    localparam int IW = 4, THW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] ptp_time = '0, sched_start = '0;
    logic start_cmd = 0, stop_cmd = 0;
    logic [THW-1:0] act_m1 = '0;
    logic tbl_we = 0; logic [IW-1:0] tbl_addr = '0; logic [DW-1:0] tbl_delta = '0;
    logic [NP-1:0] tbl_ports = '0; logic [NC-1:0] tbl_close = '0;
    logic ep_we = 0; logic [THW-1:0] ep_sel = '0; logic [IW-1:0] ep_addr = '0;
    logic [DW-1:0] ep_delta = '0; logic [IW-1:0] ep_end = '0;
    logic [NP*NC-1:0] gate_closed; logic [NT-1:0] thr_running;
    logic sts_running, sts_stopped;

    gcl_sequencer #(.NT(NT), .NP(NP), .NC(NC), .DEPTH(DEPTH), .DELTA_W(DW),
                    .TIME_W(TW), .TPU(TPU)) uut (.*);

    always #5 clk = ~clk;

    int m_base[NT], m_last[NT], m_ofs[NT], s_edge[NT];
    int t_delta[DEPTH], t_ports[DEPTH], t_close[DEPTH];
    bit run_m = 0;
    int edge_n = 0, ptp_i = 0, start_i = 0, act_i = 0;
    int vecs = 0, errs = 0;
    bit done = 0;
    string cur_req = "R1";

    function automatic int exp_ptr(int i);
        int e, per, r, k;
        e = edge_n - s_edge[i];
        per = 0;
        for (int j = m_base[i]; j <= m_last[i]; j++) per += t_delta[j] * TPU;
        r = e % per;
        k = m_base[i];
        while (r >= t_delta[k] * TPU) begin r -= t_delta[k] * TPU; k++; end
        return k;
    endfunction

    task automatic compare();
        logic [NP*NC-1:0] eg;
        logic [NT-1:0] er;
        eg = '0; er = '0;
        for (int i = 0; i < NT; i++) begin
            if (s_edge[i] >= 0) begin
                int k;
                er[i] = 1'b1;
                k = exp_ptr(i);
                for (int p = 0; p < NP; p++)
                    if (t_ports[k][p]) eg[p*NC +: NC] = eg[p*NC +: NC] | NC'(t_close[k]);
            end
        end
        vecs++;
        if (gate_closed !== eg || thr_running !== er ||
            sts_running !== run_m || sts_stopped !== !run_m) begin
            errs++;
            $display("FAIL %s edge %0d: gate %h run %b sts %b/%b, expected gate %h run %b sts %b/%b",
                     cur_req, edge_n, gate_closed, thr_running, sts_running, sts_stopped,
                     eg, er, run_m, !run_m);
        end
    endtask

    task automatic step();
        @(posedge clk);
        edge_n++;
        for (int i = 0; i < NT; i++) begin
            if (stop_cmd || !run_m || i > act_i) s_edge[i] = -1;
            else if (s_edge[i] < 0 && ptp_i >= start_i + m_ofs[i] * TPU) s_edge[i] = edge_n;
        end
        if (ep_we && ep_delta != 0) begin
            m_base[ep_sel] = ep_addr; m_last[ep_sel] = ep_end; m_ofs[ep_sel] = ep_delta;
        end
        if (tbl_we) begin
            t_delta[tbl_addr] = tbl_delta; t_ports[tbl_addr] = tbl_ports; t_close[tbl_addr] = tbl_close;
        end
        if (stop_cmd) run_m = 0; else if (start_cmd) run_m = 1;
        @(negedge clk);
        compare();
        start_cmd = 0; stop_cmd = 0; tbl_we = 0; ep_we = 0;
        ptp_i++; ptp_time = TW'(ptp_i);
    endtask

    task automatic wr_ent(int a, int dl, int pm, int cm);
        tbl_we = 1; tbl_addr = IW'(a); tbl_delta = DW'(dl);
        tbl_ports = NP'(pm); tbl_close = NC'(cm);
        step();
    endtask

    task automatic wr_ep(int t, int a, int dl, int e);
        ep_we = 1; ep_sel = THW'(t); ep_addr = IW'(a); ep_delta = DW'(dl); ep_end = IW'(e);
        step();
    endtask

    task automatic arm(int lead);
        start_i = ptp_i + lead; sched_start = TW'(start_i);
        start_cmd = 1;
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m_base[i] = 0; m_last[i] = 0; m_ofs[i] = 1; s_edge[i] = -1; end
        for (int k = 0; k < DEPTH; k++) begin t_delta[k] = 0; t_ports[k] = 0; t_close[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cur_req = "R1";
        compare();
        repeat (2) step();

        cur_req = "R8 config";
        wr_ent(0, 1, 4'b0001, 8'h01);
        wr_ent(1, 2, 4'b0001, 8'h02);
        wr_ent(2, 3, 4'b0011, 8'h80);
        wr_ent(3, 2, 4'b0010, 8'h10);
        wr_ent(4, 1, 4'b0100, 8'h04);
        wr_ent(5, 4, 4'b0010, 8'h20);
        wr_ent(6, 1, 4'b1000, 8'hFF);
        wr_ep(0, 0, 1, 2);
        wr_ep(1, 3, 3, 4);
        wr_ep(2, 5, 2, 5);
        wr_ep(3, 6, 1, 6);
        cur_req = "R10";
        wr_ep(0, 9, 0, 9);   // zero offset: whole write dropped
        act_m1 = 3'd2; act_i = 2;

        cur_req = "R2 R3";
        arm(6);
        cur_req = "R3 R4 R5 R6 R7 R8 R10";
        repeat (80) step();

        for (int off = 0; off < 14; off++) begin
            cur_req = "R9 stop sweep";
            stop_cmd = 1; step();
            step();
            cur_req = "R9 restart";
            arm(3);
            repeat (8 + off) step();
        end
        cur_req = "R9 stop";
        stop_cmd = 1; step();
        cur_req = "R9 start with stop";
        start_cmd = 1; stop_cmd = 1; step();
        step();

        cur_req = "R4 four threads";
        act_m1 = 3'd3; act_i = 3;
        arm(2);
        repeat (40) step();
        cur_req = "R4 back to three";
        act_m1 = 3'd2; act_i = 2;
        repeat (20) step();
        stop_cmd = 1; step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule